// File: doc/BRIEF.md
# AHB-Lite Burst Address Sequencer

This block is the address-phase engine of a bus master. A client hands it a start address, a transfer size and a burst kind through a one-cycle request handshake. The block then drives the address and transfer-type lines for every beat of the burst. It moves forward only on cycles where the bus reports ready. It opens each burst with a non-sequential beat and follows it with sequential beats whose addresses it computes itself. It can insert busy cycles when the client asks for them. For wrapping bursts it keeps every address inside the aligned window that the burst covers.

The block also decides whether a request can be issued at all. A fixed-length incrementing burst that would run past a 1 KB address boundary is refused. A request whose size is wider than the data bus is refused too. In both cases an error pulse is raised and no beat goes out. An incrementing burst of undefined length runs until the client asks it to stop. If such a burst reaches a 1 KB boundary, the beat at the boundary is sent as a fresh non-sequential beat.

The controller has three states. In PHASE_IDLE no transfer is shown. In PHASE_BEAT a non-sequential or sequential beat is on the bus. In PHASE_PAUSE a busy cycle shows the next beat's address. The transitions are:
- launch: PHASE_IDLE to PHASE_BEAT.
- advance: PHASE_BEAT to PHASE_BEAT.
- stall: PHASE_BEAT to PHASE_PAUSE.
- resume: PHASE_PAUSE to PHASE_BEAT.
- finish: PHASE_BEAT to PHASE_IDLE.
- chain: from the last beat straight into a new launch.

Top module: `ahb_burst_sequencer`

## Requirements
- R1: While reset is held, and after it is released, `htrans` is IDLE (00), `haddr` is 0 and `req_err` is 0.
- R2: An accepted request appears on the clock edge that accepts it. At that point `htrans` is NONSEQ (10), `haddr` equals the start address, and `hsize` and `hburst` equal the request fields. Burst codes are: SINGLE=000, INCR=001, WRAP4=010, INCR4=011, WRAP8=100, INCR8=101, WRAP16=110, INCR16=111.
- R3: In fixed incrementing bursts (INCR4, INCR8, INCR16), each later beat is SEQ (11) at the previous beat's address plus 2^hsize. The burst has exactly 4, 8 or 16 beats.
- R4: In wrapping bursts (WRAP4, WRAP8, WRAP16), each later beat is SEQ at the previous address plus 2^hsize, kept within the aligned block of beats×2^hsize bytes. For example, WRAP4 with 4-byte beats starting at 0x34 gives 0x34, 0x38, 0x3C, 0x30.
- R5: While `hready` is low, `haddr`, `htrans`, `hsize` and `hburst` do not change.
- R6: Suppose `busy_req` is high on a ready edge that ends a beat other than the last. Then `htrans` becomes BUSY (01) and `haddr` shows the next beat's address. BUSY is held on each ready edge while `busy_req` stays high. The first ready edge with `busy_req` low issues that same address as SEQ. Busy cycles do not count as beats.
- R7: An undefined-length INCR burst keeps issuing beats. A beat is the last one when `incr_stop` is high on the ready edge that ends it.
- R8: In an undefined-length INCR burst, a beat whose address has its low 10 bits at zero is issued as NONSEQ. A SEQ beat of an incrementing burst never sits at such an address.
- R9: A fixed incrementing request where (start mod 1024) + beats×2^hsize > 1024 is refused. `req_err` is high for the single cycle after the accepting edge, and `htrans` stays or becomes IDLE.
- R10: A request with `req_size` greater than 2 is refused in the same way as in R9.
- R11: `req_ready` equals `hready` ANDed with (state is PHASE_IDLE, or the current beat is the last). After the last beat `htrans` returns to IDLE, unless a request is accepted in that same cycle. In that case the new NONSEQ beat follows with no gap.
- R12: A SINGLE burst issues exactly one NONSEQ beat and ignores `busy_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hready | input | 1 | Bus ready; the address phase advances only when high |
| req_valid | input | 1 | Client offers a new burst |
| req_ready | output | 1 | A request offered now is taken on the next edge |
| req_addr | input | ADDR_W | Start address, aligned to the size |
| req_size | input | 3 | Transfer size code, bytes = 2^code |
| req_burst | input | 3 | Burst kind code (see R2) |
| busy_req | input | 1 | Ask for busy cycles before the next beat |
| incr_stop | input | 1 | Ends an undefined-length INCR burst at the current beat |
| req_err | output | 1 | One-cycle pulse: the last request was refused |
| haddr | output | ADDR_W | Address of the current address phase |
| htrans | output | 2 | Transfer type of the current address phase |
| hsize | output | 3 | Size of the current burst |
| hburst | output | 3 | Burst kind of the current burst |

## Verification
Two pairs of events can fall on the same edge. First, the finish of one burst can coincide with the launch of the next. Second, a busy request can arrive on the ready edge that closes the last beat, where it must be ignored. The bench provokes the first case by holding a new request during the last beat, and the second by holding `busy_req` high through whole SINGLE and fixed bursts. On every cycle it compares `htrans`, `haddr` and `req_ready` against a model of the phase sequence built in the bench from the requirements. Hready stalls and 1 KB crossings of undefined-length bursts are overlaid on the same runs.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        TR_IDLE = 2'b00,
        TR_BUSY = 2'b01,
        TR_NSEQ = 2'b10,
        TR_SEQ  = 2'b11
    } trans_e;

    typedef enum logic [2:0] {
        BU_SINGLE = 3'd0,
        BU_INCR   = 3'd1,
        BU_WRAP4  = 3'd2,
        BU_INCR4  = 3'd3,
        BU_WRAP8  = 3'd4,
        BU_INCR8  = 3'd5,
        BU_WRAP16 = 3'd6,
        BU_INCR16 = 3'd7
    } burst_e;

    typedef enum logic [1:0] {
        PHASE_IDLE,
        PHASE_BEAT,
        PHASE_PAUSE
    } phase_e;

    // beats in a burst kind; 0 marks undefined length
    function automatic logic [4:0] beat_count(input logic [2:0] kind);
        logic [4:0] n;
        unique case (kind)
            3'd0:       n = 5'd1;
            3'd1:       n = 5'd0;
            3'd2, 3'd3: n = 5'd4;
            3'd4, 3'd5: n = 5'd8;
            default:    n = 5'd16;
        endcase
        return n;
    endfunction

    function automatic logic is_wrap(input logic [2:0] kind);
        return !kind[0] && (kind != 3'd0);
    endfunction

    function automatic logic is_fixed_incr(input logic [2:0] kind);
        return kind[0] && (kind != 3'd1);
    endfunction

endpackage

// File: rtl/burst_next_addr.sv
module burst_next_addr
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [2:0]        size,
    input  logic [2:0]        kind,
    output logic [ADDR_W-1:0] nxt
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] linear;

    always_comb begin
        step   = ADDR_W'(1) << size;
        span   = ADDR_W'(beat_count(kind)) << size;
        mask   = span - ADDR_W'(1);
        linear = cur + step;
        if (is_wrap(kind)) begin
            nxt = (cur & ~mask) | (linear & mask);
        end else begin
            nxt = linear;
        end
    end

endmodule

// File: rtl/burst_bound_check.sv
module burst_bound_check
    import burst_seq_pkg::*;
#(
    parameter int KB_BITS  = 10,
    parameter int SIZE_MAX = 2
) (
    input  logic [KB_BITS-1:0] low_addr,
    input  logic [2:0]         size,
    input  logic [2:0]         kind,
    output logic               reject
);

    localparam int SW = KB_BITS + 8;

    logic [SW-1:0] span;
    logic [SW-1:0] end_off;
    logic          crosses;

    always_comb begin
        span    = SW'(beat_count(kind)) << size;
        end_off = SW'(low_addr) + span;
        crosses = is_fixed_incr(kind) && (end_off > (SW'(1) << KB_BITS));
        reject  = (size > 3'(SIZE_MAX)) || crosses;
    end

endmodule

// File: rtl/ahb_burst_sequencer.sv
module ahb_burst_sequencer
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int KB_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hready,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [2:0]        req_burst,
    input  logic              busy_req,
    input  logic              incr_stop,
    output logic              req_err,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic [2:0]        hsize,
    output logic [2:0]        hburst
);

    localparam int SIZE_MAX = $clog2(DATA_W / 8);

    phase_e            phase_q, phase_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    trans_e            trans_q, trans_d;
    logic [2:0]        size_q, size_d;
    logic [2:0]        kind_q, kind_d;
    logic [4:0]        left_q, left_d;
    logic              err_q;

    logic [ADDR_W-1:0] step_addr;
    logic              refused;
    logic              undef_len;
    logic              last_beat;
    logic              take;
    logic              launch;
    logic              cross_next;
    logic              cross_here;

    burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur  (addr_q),
        .size (size_q),
        .kind (kind_q),
        .nxt  (step_addr)
    );

    burst_bound_check #(.KB_BITS(KB_BITS), .SIZE_MAX(SIZE_MAX)) u_check (
        .low_addr (req_addr[KB_BITS-1:0]),
        .size     (req_size),
        .kind     (req_burst),
        .reject   (refused)
    );

    always_comb begin
        undef_len  = (kind_q == 3'(BU_INCR));
        last_beat  = (phase_q == PHASE_BEAT) && (undef_len ? incr_stop : (left_q == 5'd0));
        req_ready  = hready && ((phase_q == PHASE_IDLE) || last_beat);
        take       = req_valid && req_ready;
        launch     = take && !refused;
        cross_next = undef_len && (step_addr[KB_BITS-1:0] == '0);
        cross_here = undef_len && (addr_q[KB_BITS-1:0] == '0);
    end

    // next-state and next-output decision
    always_comb begin
        phase_d = phase_q;
        addr_d  = addr_q;
        trans_d = trans_q;
        size_d  = size_q;
        kind_d  = kind_q;
        left_d  = left_q;
        if (hready) begin
            unique case (phase_q)
                PHASE_IDLE: begin
                    if (launch) begin
                        phase_d = PHASE_BEAT;
                        addr_d  = req_addr;
                        trans_d = TR_NSEQ;
                        size_d  = req_size;
                        kind_d  = req_burst;
                        left_d  = beat_count(req_burst) - 5'd1;
                    end
                end
                PHASE_BEAT: begin
                    if (last_beat) begin
                        if (launch) begin
                            addr_d  = req_addr;
                            trans_d = TR_NSEQ;
                            size_d  = req_size;
                            kind_d  = req_burst;
                            left_d  = beat_count(req_burst) - 5'd1;
                        end else begin
                            phase_d = PHASE_IDLE;
                            trans_d = TR_IDLE;
                        end
                    end else begin
                        addr_d = step_addr;
                        left_d = left_q - 5'd1;
                        if (busy_req) begin
                            phase_d = PHASE_PAUSE;
                            trans_d = TR_BUSY;
                        end else begin
                            trans_d = cross_next ? TR_NSEQ : TR_SEQ;
                        end
                    end
                end
                PHASE_PAUSE: begin
                    if (!busy_req) begin
                        phase_d = PHASE_BEAT;
                        trans_d = cross_here ? TR_NSEQ : TR_SEQ;
                    end
                end
                default: phase_d = PHASE_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PHASE_IDLE;
            left_q  <= '0;
        end else begin
            phase_q <= phase_d;
            left_q  <= left_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            trans_q <= TR_IDLE;
            size_q  <= '0;
            kind_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            addr_q  <= addr_d;
            trans_q <= trans_d;
            size_q  <= size_d;
            kind_q  <= kind_d;
            err_q   <= take && refused;
        end
    end

    assign haddr   = addr_q;
    assign htrans  = trans_q;
    assign hsize   = size_q;
    assign hburst  = kind_q;
    assign req_err = err_q;

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> ($stable(haddr) && $stable(htrans) && $stable(hsize) && $stable(hburst)));

    assert_incr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && htrans == 2'b11 && hburst[0])
        |=> !(htrans == 2'b11 || htrans == 2'b01)
            || (haddr == $past(haddr) + (ADDR_W'(1) << $past(hsize))));

    assert_no_kb_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11 && hburst[0]) |-> (haddr[KB_BITS-1:0] != '0));

    assert_busy_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b01) |-> (hburst != 3'd0));

    assert_refuse_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (htrans == 2'b00));

    assert_size_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b11 || htrans == 2'b01) |-> $stable(hsize));

endmodule

// File: tb/tb_ahb_burst_sequencer.sv
module tb_ahb_burst_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hready = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [2:0]  req_burst = '0;
    logic        busy_req = 1'b0;
    logic        incr_stop = 1'b0;
    logic        req_err;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic [2:0]  hsize;
    logic [2:0]  hburst;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    ahb_burst_sequencer dut (
        .clk(clk), .rst_n(rst_n), .hready(hready),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_burst(req_burst),
        .busy_req(busy_req), .incr_stop(incr_stop), .req_err(req_err),
        .haddr(haddr), .htrans(htrans), .hsize(hsize), .hburst(hburst)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int beats_of(input logic [2:0] b);
        case (b)
            3'd0: return 1;
            3'd1: return 0;
            3'd2, 3'd3: return 4;
            3'd4, 3'd5: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [31:0] next_a(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] b);
        logic [31:0] inc;
        logic [31:0] msk;
        inc = 32'd1 << sz;
        if (b != 3'd0 && !b[0]) begin
            msk = (32'(beats_of(b)) << sz) - 32'd1;
            return (a & ~msk) | ((a + inc) & msk);
        end
        return a + inc;
    endfunction

    function automatic bit crosses(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] b);
        if (!b[0] || b == 3'd1) return 0;
        return (int'(a[9:0]) + (beats_of(b) << sz)) > 1024;
    endfunction

    // Model-checked burst with random stalls and busy cycles
    task automatic run_burst(input logic [31:0] st, input logic [2:0] sz, input logic [2:0] bu,
                             input int ulen, input int busy_pct, input int rdy_pct, input string tag);
        logic [1:0]  et;
        logic [31:0] ea;
        int          k;
        int          total;
        bit          fin;
        total = (bu == 3'd1) ? ulen : beats_of(bu);
        hready = 1'b1; busy_req = 1'b0; incr_stop = 1'b0;
        req_valid = 1'b1; req_addr = st; req_size = sz; req_burst = bu;
        #1 check(req_ready == 1'b1, "R11 ready when idle", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        et = 2'b10; ea = st; k = 0; fin = 0;
        check(htrans == et, "R2 first beat NONSEQ", 32'(htrans), 32'(et));
        check(haddr == ea, "R2 start address", haddr, ea);
        check(hsize == sz && hburst == bu, "R2 size/burst", {26'd0, hsize, hburst}, {26'd0, sz, bu});
        while (!fin) begin
            hready    = ($urandom % 100) < rdy_pct;
            busy_req  = ($urandom % 100) < busy_pct;
            incr_stop = (k == total - 1);
            #1;
            check(req_ready == (hready && (et == 2'b10 || et == 2'b11) && k == total - 1),
                  "R11 ready level", 32'(req_ready), 32'(hready && k == total - 1));
            if (hready) begin
                if (et == 2'b10 || et == 2'b11) begin
                    if (k == total - 1) begin
                        et = 2'b00; fin = 1;
                    end else begin
                        ea = next_a(ea, sz, bu); k++;
                        if (busy_req) et = 2'b01;
                        else et = (bu == 3'd1 && ea[9:0] == 10'd0) ? 2'b10 : 2'b11;
                    end
                end else if (et == 2'b01 && !busy_req) begin
                    et = (bu == 3'd1 && ea[9:0] == 10'd0) ? 2'b10 : 2'b11;
                end
            end
            @(negedge clk);
            check(htrans == et, {tag, " htrans"}, 32'(htrans), 32'(et));
            if (!fin) check(haddr == ea, {tag, " haddr"}, haddr, ea);
        end
        busy_req = 1'b0; incr_stop = 1'b0; hready = 1'b1;
    endtask

    // Explicit expected sequence, no stalls, stop on beat n-1
    task automatic seq_direct(input logic [31:0] st, input logic [2:0] sz, input logic [2:0] bu,
                              input int n, input logic [31:0] ea[4], input logic [1:0] et[4], input string tag);
        hready = 1'b1; busy_req = 1'b0; incr_stop = 1'b0;
        req_valid = 1'b1; req_addr = st; req_size = sz; req_burst = bu;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            check(htrans == et[i], {tag, " htrans"}, 32'(htrans), 32'(et[i]));
            check(haddr == ea[i], {tag, " haddr"}, haddr, ea[i]);
            incr_stop = (i == n - 1);
            @(negedge clk);
        end
        incr_stop = 1'b0;
        check(htrans == 2'b00, {tag, " ends idle"}, 32'(htrans), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ea[4];
        logic [1:0]  et[4];
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(htrans == 2'b00, "R1 htrans in reset", 32'(htrans), 0);
        check(haddr == 32'd0, "R1 haddr in reset", haddr, 0);
        check(req_err == 1'b0, "R1 err in reset", 32'(req_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(htrans == 2'b00 && haddr == 0, "R1 after reset", {30'd0, htrans}, 0);

        // R4 wrap example
        ea = '{32'h34, 32'h38, 32'h3C, 32'h30};
        et = '{2'b10, 2'b11, 2'b11, 2'b11};
        seq_direct(32'h34, 3'd2, 3'd2, 4, ea, et, "R4 wrap4 at 0x34");

        // R8 undefined burst crossing 1KB restarts as NONSEQ; R7 stop
        ea = '{32'h3F8, 32'h3FC, 32'h400, 32'h404};
        et = '{2'b10, 2'b11, 2'b10, 2'b11};
        seq_direct(32'h3F8, 3'd2, 3'd1, 4, ea, et, "R8 R7 undefined crossing");

        // R9 refused crossing INCR16
        req_valid = 1'b1; req_addr = 32'h3F0; req_size = 3'd2; req_burst = 3'd7;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err == 1'b1, "R9 err pulse", 32'(req_err), 1);
        check(htrans == 2'b00, "R9 nothing issued", 32'(htrans), 0);
        @(negedge clk);
        check(req_err == 1'b0, "R9 err one cycle", 32'(req_err), 0);
        check(htrans == 2'b00, "R9 still idle", 32'(htrans), 0);

        // R10 oversize refused
        req_valid = 1'b1; req_addr = 32'h80; req_size = 3'd3; req_burst = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_err == 1'b1 && htrans == 2'b00, "R10 oversize refused", {30'd0, req_err, htrans[0]}, 32'h2);
        @(negedge clk);

        // R11 no accept while hready low
        hready = 1'b0; req_valid = 1'b1; req_addr = 32'h500; req_size = 3'd2; req_burst = 3'd0;
        #1 check(req_ready == 1'b0, "R11 ready low with hready low", 32'(req_ready), 0);
        @(negedge clk);
        check(htrans == 2'b00, "R11 not launched", 32'(htrans), 0);
        req_valid = 1'b0; hready = 1'b1;

        // R5 hold during stall
        req_valid = 1'b1; req_addr = 32'h40; req_size = 3'd1; req_burst = 3'd5;
        @(negedge clk);
        req_valid = 1'b0; hready = 1'b0; busy_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(htrans == 2'b10 && haddr == 32'h40, "R5 held while not ready", haddr, 32'h40);
        end
        hready = 1'b1; busy_req = 1'b0;
        @(negedge clk);
        check(htrans == 2'b11 && haddr == 32'h42, "R5 R3 resumes", haddr, 32'h42);
        for (int i = 0; i < 20 && htrans != 2'b00; i++) @(negedge clk);
        check(htrans == 2'b00, "R3 INCR8 drains", 32'(htrans), 0);

        // R11 back-to-back chaining
        req_valid = 1'b1; req_addr = 32'h100; req_size = 3'd2; req_burst = 3'd3;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        #1 check(req_ready == 1'b0, "R11 not ready mid-burst", 32'(req_ready), 0);
        @(negedge clk);
        @(negedge clk);
        check(haddr == 32'h10C, "R3 fourth beat", haddr, 32'h10C);
        req_valid = 1'b1; req_addr = 32'h200; req_burst = 3'd0; busy_req = 1'b1;
        #1 check(req_ready == 1'b1, "R11 ready on last beat", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(htrans == 2'b10 && haddr == 32'h200, "R11 chained NONSEQ", haddr, 32'h200);
        @(negedge clk);
        check(htrans == 2'b00, "R12 single ignores busy", 32'(htrans), 0);
        busy_req = 1'b0;

        // R12 single with busy always requested
        run_burst(32'h7C, 3'd2, 3'd0, 0, 100, 80, "R12 single");

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [2:0]  sz;
            logic [2:0]  bu;
            logic [31:0] a;
            string       tg;
            sz = 3'($urandom % 3);
            bu = 3'($urandom % 8);
            a  = ($urandom & 32'hFFFF) & ~((32'd1 << sz) - 1);
            while (crosses(a, sz, bu)) a = ($urandom & 32'hFFFF) & ~((32'd1 << sz) - 1);
            if (bu == 3'd1) begin
                a = {a[31:10], 10'h3C0} & ~((32'd1 << sz) - 1);
                tg = "R7 R8 undefined";
            end else if (bu == 3'd0) tg = "R12 single";
            else if (bu[0]) tg = "R3 R6 incr";
            else tg = "R4 R6 wrap";
            run_burst(a, sz, bu, 4 + int'($urandom % 30), 30, 70, tg);
        end

        done_flag = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule